// File: doc/BRIEF.md
# Programmable I2C SCL Timing Generator

This block turns a 32-bit clock-control word into the SCL waveform timing of an I2C controller. From a free-running source clock it produces a released/driven SCL level, one level strobe for each phase, and a one-cycle tick on the first cycle of every phase. A bit engine uses these ticks to place SDA changes and samples.

The control word holds three 8-bit fields. Bits 7:0 hold the low-phase divider. Bits 23:16 hold an optional high-time divider. Bits 15:8 hold a high-speed divider that this block does not use. With the high-time field at zero the waveform is symmetric, which suits standard mode. With the field nonzero the high and low phases take separate lengths, giving the roughly one-third high, two-thirds low shape used in fast modes up to 1 MHz.

For example, a 19.2 MHz source at 100 kHz uses a low divider of 93 and a high-time field of 0. At 400 kHz it uses a low divider of 28 and a high-time field of 14. The control word is taken only as a low phase begins. A change written at any other time therefore never shortens the phase that is running. There is no data stream here: every pin is a plain control or status pin, with no valid/ready handshake and no back-pressure.

Top module: `scl_timing_gen`

## Requirements
- R1: After reset, with `en` low, `scl_out` is 1, both phase strobes are 0 and no tick is produced.
- R2: On the first rising clock edge that samples `en` high while the block is idle, `scl_out` goes to 0 and `edge_fall` is 1 for that cycle.
- R3: With bits 23:16 of `ctl_word` equal to zero, the low phase and the high phase each last (bits 7:0) + 3 clock cycles.
- R4: With bits 23:16 nonzero, the high phase lasts (bits 23:16) + 3 cycles and the low phase lasts (bits 7:0) + 3 cycles.
- R5: `edge_fall` is 1 only on the first cycle of each low phase and `edge_rise` only on the first cycle of each high phase. While enabled, `scl_out` changes only together with one of these ticks, and the two ticks are never 1 together.
- R6: `scl_lo_ph` is 1 exactly during low phases and `scl_hi_ph` exactly during high phases. Both are 0 while idle.
- R7: `ctl_word` is sampled only on the cycle in which a low phase starts, either from idle or at the end of a high phase. Both phases of that SCL period use the sampled value, and a change made during the period takes effect at the next low phase.
- R8: On the first edge that samples `en` low, `scl_out` returns to 1, both strobes go to 0 and no ticks occur until `en` is high again, which restarts the sequence as in R2.
- R9: Bits 15:8 and 31:24 of `ctl_word` have no effect on the timing.
- R10: A low divider of 0 gives 3-cycle phases. A divider of 255, or a high-time field of 255, gives a 258-cycle phase.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Source clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Run enable; low holds SCL released |
| ctl_word | input | 32 | Clock-control word (7:0 low divider, 15:8 unused high-speed divider, 23:16 high-time divider) |
| scl_out | output | 1 | SCL level, 1 = released, 0 = driven low |
| scl_lo_ph | output | 1 | High during the low phase |
| scl_hi_ph | output | 1 | High during the high phase |
| edge_fall | output | 1 | One-cycle tick on the first cycle of a low phase |
| edge_rise | output | 1 | One-cycle tick on the first cycle of a high phase |

## Verification
The phase lengths are tried with the standard-mode and fast-mode settings for a 19.2 MHz source. The zero high-time field and the nonzero one separate the symmetric path from the asymmetric path. Extreme dividers of 0 and 255 in each field catch counter reload and width faults. A second word that differs only in the unused bytes shows whether those bits leak into the timing. A word changed in the middle of a low phase tells a design that samples at the low-phase start apart from one that reacts at once. Random words then mix all of these cases. Dropping and raising the enable in the middle of a phase shows whether the release and the restart are clean.

// File: rtl/scl_gen_pkg.sv
package scl_gen_pkg;

  // Phase of the generated SCL waveform.
  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_LOW  = 2'd1,
    PH_HIGH = 2'd2
  } scl_phase_e;

endpackage

// File: rtl/scl_len_cfg.sv
// Derives the low and high phase lengths from the control word.
// The low length is used as it is loaded; the high length is kept in a
// shadow register so that the whole SCL period uses one sampled word.
module scl_len_cfg #(
  parameter int REG_W   = 32,
  parameter int FIELD_W = 8,
  parameter int LO_LSB  = 0,
  parameter int HT_LSB  = 16,
  parameter int EXTRA   = 3,
  parameter bit ASYM_EN = 1'b1,
  localparam int CNT_W  = FIELD_W + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [REG_W-1:0] ctl_word,
  output logic [CNT_W-1:0] lo_len,
  output logic [CNT_W-1:0] hi_len
);

  localparam logic [REG_W-1:0] FIELD_ONES = REG_W'((1 << FIELD_W) - 1);
  localparam logic [REG_W-1:0] USED_MASK  =
    (FIELD_ONES << LO_LSB) | (ASYM_EN ? (FIELD_ONES << HT_LSB) : '0);

  logic [FIELD_W-1:0] lo_fld;
  logic [CNT_W-1:0]   hi_next;
  logic [CNT_W-1:0]   hi_q;
  logic               unused_ctl_bits;

  assign lo_fld = ctl_word[LO_LSB +: FIELD_W];
  assign lo_len = CNT_W'(lo_fld) + CNT_W'(EXTRA);

  // Bits outside the used fields take no part in the timing.
  assign unused_ctl_bits = ^(ctl_word & ~USED_MASK);

  generate
    if (ASYM_EN) begin : g_asym
      logic [FIELD_W-1:0] ht_fld;
      assign ht_fld  = ctl_word[HT_LSB +: FIELD_W];
      assign hi_next = (ht_fld == '0) ? lo_len
                                      : CNT_W'(ht_fld) + CNT_W'(EXTRA);
    end else begin : g_sym
      assign hi_next = lo_len;
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_q <= CNT_W'(EXTRA);
    end else if (load) begin
      hi_q <= hi_next;
    end
  end

  assign hi_len = hi_q;

endmodule

// File: rtl/scl_phase_seq.sv
// Sequences idle, low and high phases with a down counter that is
// reloaded with length-1 at each phase boundary.
module scl_phase_seq
  import scl_gen_pkg::*;
#(
  parameter int CNT_W = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic [CNT_W-1:0] lo_len,
  input  logic [CNT_W-1:0] hi_len,
  output logic             load,
  output scl_phase_e       phase,
  output logic             edge_fall,
  output logic             edge_rise
);

  scl_phase_e       ph_q;
  logic [CNT_W-1:0] cnt_q;
  logic             cnt_zero;

  assign cnt_zero = (cnt_q == '0);

  // A new word is taken only as a low phase begins: either while idle
  // or when SCL is high and its last cycle is running.
  assign load = en && ((ph_q == PH_IDLE) || ((ph_q == PH_HIGH) && cnt_zero));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q      <= PH_IDLE;
      cnt_q     <= '0;
      edge_fall <= 1'b0;
      edge_rise <= 1'b0;
    end else begin
      edge_fall <= 1'b0;
      edge_rise <= 1'b0;
      if (!en) begin
        ph_q  <= PH_IDLE;
        cnt_q <= '0;
      end else begin
        unique case (ph_q)
          PH_IDLE: begin
            ph_q      <= PH_LOW;
            cnt_q     <= lo_len - CNT_W'(1);
            edge_fall <= 1'b1;
          end
          PH_LOW: begin
            if (cnt_zero) begin
              ph_q      <= PH_HIGH;
              cnt_q     <= hi_len - CNT_W'(1);
              edge_rise <= 1'b1;
            end else begin
              cnt_q <= cnt_q - CNT_W'(1);
            end
          end
          PH_HIGH: begin
            if (cnt_zero) begin
              ph_q      <= PH_LOW;
              cnt_q     <= lo_len - CNT_W'(1);
              edge_fall <= 1'b1;
            end else begin
              cnt_q <= cnt_q - CNT_W'(1);
            end
          end
          default: begin
            ph_q  <= PH_IDLE;
            cnt_q <= '0;
          end
        endcase
      end
    end
  end

  assign phase = ph_q;

endmodule

// File: rtl/scl_timing_gen.sv
// Top level: programmable SCL phase timing from a clock-control word.
module scl_timing_gen
  import scl_gen_pkg::*;
#(
  parameter int REG_W   = 32,
  parameter int FIELD_W = 8,
  parameter int LO_LSB  = 0,
  parameter int HT_LSB  = 16,
  parameter int EXTRA   = 3,
  parameter bit ASYM_EN = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic [REG_W-1:0] ctl_word,
  output logic             scl_out,
  output logic             scl_lo_ph,
  output logic             scl_hi_ph,
  output logic             edge_fall,
  output logic             edge_rise
);

  localparam int CNT_W = FIELD_W + 1;

  logic [CNT_W-1:0] lo_len;
  logic [CNT_W-1:0] hi_len;
  logic             load;
  scl_phase_e       phase;

  scl_len_cfg #(
    .REG_W  (REG_W),
    .FIELD_W(FIELD_W),
    .LO_LSB (LO_LSB),
    .HT_LSB (HT_LSB),
    .EXTRA  (EXTRA),
    .ASYM_EN(ASYM_EN)
  ) u_cfg (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (load),
    .ctl_word(ctl_word),
    .lo_len  (lo_len),
    .hi_len  (hi_len)
  );

  scl_phase_seq #(
    .CNT_W(CNT_W)
  ) u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .en       (en),
    .lo_len   (lo_len),
    .hi_len   (hi_len),
    .load     (load),
    .phase    (phase),
    .edge_fall(edge_fall),
    .edge_rise(edge_rise)
  );

  assign scl_lo_ph = (phase == PH_LOW);
  assign scl_hi_ph = (phase == PH_HIGH);
  assign scl_out   = (phase != PH_LOW);

endmodule

// File: rtl/scl_timing_chk.sv
// Property checker attached to the top module through bind.
module scl_timing_chk (
  input logic clk,
  input logic rst_n,
  input logic en,
  input logic scl_out,
  input logic scl_lo_ph,
  input logic scl_hi_ph,
  input logic edge_fall,
  input logic edge_rise
);

  assert_idle_released_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(en) |-> (scl_out && !scl_lo_ph && !scl_hi_ph && !edge_fall && !edge_rise))
    else $error("R8: outputs not idle after enable low");

  assert_start_low_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(en) && !$past(en, 2)) |-> (edge_fall && !scl_out))
    else $error("R2: start did not enter low phase");

  assert_tick_exclusive_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !(edge_fall && edge_rise))
    else $error("R5: both ticks at once");

  assert_rise_from_low_R5: assert property (@(posedge clk) disable iff (!rst_n)
    edge_rise |-> (scl_out && scl_hi_ph && !$past(scl_out)))
    else $error("R5: rise tick without low-to-high change");

  assert_fall_from_high_R5: assert property (@(posedge clk) disable iff (!rst_n)
    edge_fall |-> (!scl_out && scl_lo_ph && $past(scl_out)))
    else $error("R5: fall tick without high-to-low change");

  assert_change_has_tick_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(en) && !$stable(scl_out)) |-> (edge_fall || edge_rise))
    else $error("R5: SCL changed without a tick");

  assert_strobe_excl_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !(scl_lo_ph && scl_hi_ph))
    else $error("R6: both phase strobes set");

  assert_min_low_R10: assert property (@(posedge clk) disable iff (!rst_n)
    edge_fall |=> !edge_rise ##1 !edge_rise)
    else $error("R10: low phase shorter than 3 cycles");

  assert_min_high_R10: assert property (@(posedge clk) disable iff (!rst_n)
    edge_rise |=> !edge_fall ##1 !edge_fall)
    else $error("R10: high phase shorter than 3 cycles");

endmodule

bind scl_timing_gen scl_timing_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .en       (en),
  .scl_out  (scl_out),
  .scl_lo_ph(scl_lo_ph),
  .scl_hi_ph(scl_hi_ph),
  .edge_fall(edge_fall),
  .edge_rise(edge_rise)
);

// File: tb/tb_scl_timing_gen.sv
module tb_scl_timing_gen;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        en;
  logic [31:0] ctl_word;
  logic        scl_out, scl_lo_ph, scl_hi_ph, edge_fall, edge_rise;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  logic s_scl, s_lo, s_hi, s_fall, s_rise;

  always #(CLK_PERIOD / 2) clk = ~clk;

  scl_timing_gen dut (
    .clk      (clk),
    .rst_n    (rst_n),
    .en       (en),
    .ctl_word (ctl_word),
    .scl_out  (scl_out),
    .scl_lo_ph(scl_lo_ph),
    .scl_hi_ph(scl_hi_ph),
    .edge_fall(edge_fall),
    .edge_rise(edge_rise)
  );

  function automatic int exp_lo(input logic [31:0] w);
    return int'(w[7:0]) + 3;
  endfunction

  function automatic int exp_hi(input logic [31:0] w);
    return (w[23:16] == 8'd0) ? int'(w[7:0]) + 3 : int'(w[23:16]) + 3;
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Advance to the next falling edge and sample the outputs there.
  task automatic step();
    @(negedge clk);
    s_scl  = scl_out;
    s_lo   = scl_lo_ph;
    s_hi   = scl_hi_ph;
    s_fall = edge_fall;
    s_rise = edge_rise;
  endtask

  // Starts on a sample that shows edge_fall; ends on the next such sample.
  task automatic measure(output int lo, output int hi);
    int errs;
    lo = 0; hi = 0; errs = 0;
    if (!s_fall) errs++;
    while (!s_scl) begin
      lo++;
      if (!s_lo || s_hi) errs++;
      if (lo > 1 && (s_fall || s_rise)) errs++;
      step();
    end
    if (!s_rise) errs++;
    while (s_scl) begin
      hi++;
      if (!s_hi || s_lo) errs++;
      if (hi > 1 && (s_fall || s_rise)) errs++;
      step();
    end
    chk(errs == 0, "R5 R6 tick/strobe placement", errs, 0);
  endtask

  // Applies a word at a fall sample, skips the mixed period, measures the next.
  task automatic apply_and_measure(input logic [31:0] w, input string req);
    int lo, hi;
    ctl_word = w;
    measure(lo, hi);
    measure(lo, hi);
    chk(lo == exp_lo(w), {req, " low length"}, lo, exp_lo(w));
    chk(hi == exp_hi(w), {req, " high length"}, hi, exp_hi(w));
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=expired expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin : main
    int lo, hi, ticks, seed_init;
    logic [31:0] w_old, w;
    seed_init = $urandom(32'd2718);
    rst_n = 1'b0;
    en = 1'b0;
    ctl_word = 32'h0000_035D;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    step();
    chk(s_scl && !s_lo && !s_hi && !s_fall && !s_rise, "R1 reset idle", int'(s_scl), 1);
    ticks = 0;
    repeat (5) begin
      step();
      if (s_fall || s_rise || !s_scl) ticks++;
    end
    chk(ticks == 0, "R1 idle with enable low", ticks, 0);

    // Standard mode, 100 kHz from 19.2 MHz: divider 93, no high-time field.
    en = 1'b1;
    step();
    chk(s_fall && !s_scl, "R2 start on first enabled edge", int'(s_fall), 1);
    measure(lo, hi);
    chk(lo == 96, "R3 standard low", lo, 96);
    chk(hi == 96, "R3 standard high", hi, 96);

    // R7: change mid low phase; this period keeps the old word.
    w_old = ctl_word;
    step();
    ctl_word = 32'h000E_031C;
    while (!s_fall) step();
    measure(lo, hi);
    chk(lo == exp_lo(32'h000E_031C), "R7 new word at next low", lo, 31);
    chk(hi == 17, "R4 fast high", hi, 17);
    chk(w_old == 32'h0000_035D, "R7 bench word", int'(w_old[7:0]), 93);

    // R7 again: change at a fall sample, so the current period stays old.
    ctl_word = 32'h0000_0005;
    measure(lo, hi);
    chk(lo == 31 && hi == 17, "R7 running period keeps old word", lo, 31);
    measure(lo, hi);
    chk(lo == 8 && hi == 8, "R7 following period uses new word", hi, 8);

    apply_and_measure(32'h000E_031C, "R4 fast 400k");
    apply_and_measure(32'h5C0E_A51C, "R9 unused bytes ignored");
    apply_and_measure(32'hFF00_FF00, "R10 divider zero");
    apply_and_measure(32'h0000_00FF, "R10 divider max");
    apply_and_measure(32'h00FF_0000, "R10 high-time max");
    apply_and_measure(32'h0001_0000, "R4 high-time one");

    // R8: drop enable in the middle of a low phase.
    step();
    en = 1'b0;
    step();
    chk(s_scl && !s_lo && !s_hi && !s_fall && !s_rise, "R8 release on enable low", int'(s_scl), 1);
    ticks = 0;
    repeat (6) begin
      step();
      if (s_fall || s_rise || !s_scl || s_lo || s_hi) ticks++;
    end
    chk(ticks == 0, "R8 quiet while disabled", ticks, 0);
    en = 1'b1;
    step();
    chk(s_fall && !s_scl, "R8 R2 restart", int'(s_fall), 1);
    measure(lo, hi);
    chk(lo == exp_lo(ctl_word) && hi == exp_hi(ctl_word), "R8 restart timing", lo, exp_lo(ctl_word));

    // Random words with small dividers.
    for (int i = 0; i < 12; i++) begin
      w = $urandom;
      w[7:0] = 8'($urandom_range(0, 40));
      w[23:16] = ($urandom_range(0, 1) == 0) ? 8'd0 : 8'($urandom_range(1, 40));
      apply_and_measure(w, (w[23:16] == 8'd0) ? "R3 random symmetric" : "R4 random asymmetric");
    end

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule